// File: doc/BRIEF.md
# Low-Power Standby Mode Controller

This block sits beside a small CPU core and governs its two low-power states. In sleep, only the CPU clock is halted. In stop, the CPU clock and the source oscillator are both halted. Software requests a state by writing a sleep bit and a stop bit. Peripheral interrupt requests, each tagged with a 2-bit priority level, can do two things: a live request stops the controller from entering standby, and a live request also brings the controller back out of standby.

When the controller leaves standby it emits a one-clock wake pulse. With the pulse it gives a decision: branch to the interrupt handler, or resume at the instruction after the one that entered standby. Leaving stop takes longer than leaving sleep. The oscillator restarts first, and the CPU clock stays halted for a selectable settling count while a busy flag is raised.

Levels are encoded as follows: 2'b00 is the highest priority, 2'b10 is the lowest active level, and 2'b11 means disabled. A request is live when its request bit is 1 and its level is not 2'b11.

Top module: `stby_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to run: `cpu_clk_halt`=0, `osc_en`=1, `stab_busy`=0, `wake_pulse`=0, `wake_accept`=0, `sleep_rd`=0, `stop_rd`=0.
- R2: In run, a write with sleep=1 and stop=0 and no live request sets `cpu_clk_halt`=1 and `sleep_rd`=1 from the next cycle on. `osc_en` stays 1.
- R3: In run, a write with stop=1 and no live request selects stop, whatever the sleep bit holds. From the next cycle, `cpu_clk_halt`=1, `osc_en`=0, `stop_rd`=1 and `sleep_rd`=0.
- R4: A standby write made while any request is live is ignored, whatever `cpu_ie` and `cpu_mask_lvl` hold. When the request later drops, no deferred entry follows. A fresh write made after the request drops does take effect.
- R5: A request at level 2'b11 neither blocks entry nor wakes the block from sleep or stop.
- R6: In sleep, a live request ends standby at the next edge: `cpu_clk_halt`=0 and `wake_pulse`=1 for exactly one cycle, with no busy phase.
- R7: In stop, a live request raises `osc_en` and `stab_busy` at the next edge. `stab_busy` then stays high for exactly 2^E cycles while `cpu_clk_halt` stays 1. E is chosen by `stab_sel`, sampled at the wake edge: 00→4, 01→8, 10→12, 11→14. In the cycle after the last busy cycle, `wake_pulse`=1 and `cpu_clk_halt`=0.
- R8: `wake_accept` is 1 in the pulse cycle only if both of these hold: `cpu_ie`=1, and the numerically smallest live level is numerically below `cpu_mask_lvl`. Otherwise it is 0, meaning resume. The inputs are sampled at the edge where the wake is detected.
- R9: After a wake, `sleep_rd` and `stop_rd` read 0. A write with both bits 0 has no effect.
- R10: `wake_accept` is 0 in every cycle where `wake_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the standby bits |
| ctl_sleep | input | 1 | Sleep bit write data |
| ctl_stop | input | 1 | Stop bit write data |
| irq_req | input | NUM_REQ | Peripheral request flags |
| irq_lvl | input | 2*NUM_REQ | Per-request levels; request i uses bits [2i+1:2i] |
| cpu_mask_lvl | input | 2 | CPU current interrupt level mask |
| cpu_ie | input | 1 | CPU global interrupt enable |
| stab_sel | input | 2 | Settling count select |
| cpu_clk_halt | output | 1 | 1 halts the CPU clock |
| osc_en | output | 1 | Source oscillator enable |
| stab_busy | output | 1 | Settling count in progress |
| wake_pulse | output | 1 | One-cycle pulse when the CPU clock resumes |
| wake_accept | output | 1 | With the pulse: 1 branch to handler, 0 resume |
| sleep_rd | output | 1 | Sleep bit read-back |
| stop_rd | output | 1 | Stop bit read-back |

## Verification
Entry, blocking, wake from sleep and the accept decision are all due one clock edge after the stimulus. The bench therefore drives inputs on a falling edge and samples at the following falling edge. The one exception is wake from stop. There, the busy flag appears one edge after the request, and the bench counts the busy cycles one sample at a time against 2^E before it expects the pulse on the next sample. Cases where an input should have no effect are checked by sampling the halt, read-back and pulse outputs over several cycles before any further stimulus.

// File: rtl/stby_pkg.sv
// Shared types and helpers for the standby controller.
// Assumes 2-bit levels where a smaller value means higher priority and 2'b11 means disabled.
package stby_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_STOP   = 2'd2,
        ST_SETTLE = 2'd3
    } stby_state_t;

    localparam int unsigned LVL_W   = 2;
    localparam logic [1:0]  LVL_OFF = 2'b11;

    // Branch decision: the request level must beat the mask and interrupts must be enabled.
    function automatic logic accept_f(input logic [1:0] lvl, input logic [1:0] mask, input logic ie);
        return ie && (lvl < mask);
    endfunction
endpackage

// File: rtl/stby_req_eval.sv
// Request evaluator: finds whether any request is live and the best (smallest) live level.
// Purely combinational; assumes levels are packed two bits per request.
module stby_req_eval
    import stby_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0]       req,
    input  logic [NUM_REQ*LVL_W-1:0] lvl,
    output logic                     any_live,
    output logic [LVL_W-1:0]         best_lvl
);
    logic [NUM_REQ-1:0] live;
    logic [LVL_W-1:0]   lvl_eff [NUM_REQ];

    // One qualifier per request: live only when flagged and not disabled.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        assign live[i]    = req[i] && (lvl[i*LVL_W +: LVL_W] != LVL_OFF);
        assign lvl_eff[i] = live[i] ? lvl[i*LVL_W +: LVL_W] : LVL_OFF;
    end

    // Reduce to the numerically smallest live level.
    always_comb begin
        best_lvl = LVL_OFF;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (lvl_eff[i] < best_lvl) best_lvl = lvl_eff[i];
        end
    end

    assign any_live = |live;
endmodule

// File: rtl/stby_stab_timer.sv
// Oscillator settling counter: loads 2^E-1 for the selected exponent and counts down to zero.
// Assumes load and run are never both high; done is high whenever the count is zero.
module stby_stab_timer #(
    parameter int unsigned EXP0 = 4,
    parameter int unsigned EXP1 = 8,
    parameter int unsigned EXP2 = 12,
    parameter int unsigned EXP3 = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    input  logic       run,
    output logic       done
);
    localparam int unsigned MAX01 = (EXP0 > EXP1) ? EXP0 : EXP1;
    localparam int unsigned MAX23 = (EXP2 > EXP3) ? EXP2 : EXP3;
    localparam int unsigned CNT_W = (MAX01 > MAX23) ? MAX01 : MAX23;

    logic [CNT_W-1:0] cnt_q;

    // Start value for each select code.
    function automatic logic [CNT_W-1:0] span_m1(input logic [1:0] s);
        case (s)
            2'd0:    return (CNT_W'(1) << EXP0) - CNT_W'(1);
            2'd1:    return (CNT_W'(1) << EXP1) - CNT_W'(1);
            2'd2:    return (CNT_W'(1) << EXP2) - CNT_W'(1);
            default: return (CNT_W'(1) << EXP3) - CNT_W'(1);
        endcase
    endfunction

    // Counter register: load on stop wake, decrement while settling.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= span_m1(sel);
        else if (run && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/stby_seq.sv
// Standby sequencer: run/sleep/stop/settle state machine with the wake pulse and accept decision.
// Assumes writes only arrive while the CPU runs; writes seen in any other state are ignored.
module stby_seq
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic        wr_sleep,
    input  logic        wr_stop,
    input  logic        any_live,
    input  logic [1:0]  best_lvl,
    input  logic [1:0]  mask_lvl,
    input  logic        ie,
    input  logic        tmr_done,
    output stby_state_t state,
    output logic        tmr_load,
    output logic        pulse,
    output logic        accept
);
    stby_state_t state_q;
    logic        held_q;
    logic        decide;

    // Accept decision from the inputs at the wake-detect edge.
    assign decide = accept_f(best_lvl, mask_lvl, ie);

    // State register with the wake pulse and accept outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pulse   <= 1'b0;
            accept  <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            pulse  <= 1'b0;
            accept <= 1'b0;
            case (state_q)
                ST_RUN: begin
                    if (wr && (wr_sleep || wr_stop) && !any_live)
                        state_q <= wr_stop ? ST_STOP : ST_SLEEP;
                end
                ST_SLEEP: begin
                    if (any_live) begin
                        state_q <= ST_RUN;
                        pulse   <= 1'b1;
                        accept  <= decide;
                    end
                end
                ST_STOP: begin
                    if (any_live) begin
                        state_q <= ST_SETTLE;
                        held_q  <= decide;
                    end
                end
                default: begin
                    if (tmr_done) begin
                        state_q <= ST_RUN;
                        pulse   <= 1'b1;
                        accept  <= held_q;
                    end
                end
            endcase
        end
    end

    assign tmr_load = (state_q == ST_STOP) && any_live;
    assign state    = state_q;
endmodule

// File: rtl/stby_ctrl.sv
// Standby controller top: ties together request evaluation, sequencing and oscillator settling.
// Assumes a free-running clk independent of the CPU clock it halts; reset is synchronous, active low.
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4,
    parameter int unsigned EXP0    = 4,
    parameter int unsigned EXP1    = 8,
    parameter int unsigned EXP2    = 12,
    parameter int unsigned EXP3    = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic                 ctl_sleep,
    input  logic                 ctl_stop,
    input  logic [NUM_REQ-1:0]   irq_req,
    input  logic [2*NUM_REQ-1:0] irq_lvl,
    input  logic [1:0]           cpu_mask_lvl,
    input  logic                 cpu_ie,
    input  logic [1:0]           stab_sel,
    output logic                 cpu_clk_halt,
    output logic                 osc_en,
    output logic                 stab_busy,
    output logic                 wake_pulse,
    output logic                 wake_accept,
    output logic                 sleep_rd,
    output logic                 stop_rd
);
    logic        any_live;
    logic [1:0]  best_lvl;
    logic        tmr_load;
    logic        tmr_done;
    stby_state_t state;

    // Live-request detection and best level.
    stby_req_eval #(.NUM_REQ(NUM_REQ)) u_eval (
        .req      (irq_req),
        .lvl      (irq_lvl),
        .any_live (any_live),
        .best_lvl (best_lvl)
    );

    // Mode sequencing.
    stby_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wr_sleep (ctl_sleep),
        .wr_stop  (ctl_stop),
        .any_live (any_live),
        .best_lvl (best_lvl),
        .mask_lvl (cpu_mask_lvl),
        .ie       (cpu_ie),
        .tmr_done (tmr_done),
        .state    (state),
        .tmr_load (tmr_load),
        .pulse    (wake_pulse),
        .accept   (wake_accept)
    );

    // Oscillator settling count.
    stby_stab_timer #(.EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .sel   (stab_sel),
        .run   (state == ST_SETTLE),
        .done  (tmr_done)
    );

    // Output decode from the sequencer state.
    assign cpu_clk_halt = (state != ST_RUN);
    assign osc_en       = (state != ST_STOP);
    assign stab_busy    = (state == ST_SETTLE);
    assign sleep_rd     = (state == ST_SLEEP);
    assign stop_rd      = (state == ST_STOP) || (state == ST_SETTLE);
endmodule

// File: rtl/stby_ctrl_chk.sv
// Assertion checker for stby_ctrl, attached through bind; relates the top ports over time.
// Assumes the same request encoding as the design; recomputes liveness from the ports.
module stby_ctrl_chk #(
    parameter int unsigned NUM_REQ = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctl_wr,
    input logic                 ctl_sleep,
    input logic                 ctl_stop,
    input logic [NUM_REQ-1:0]   irq_req,
    input logic [2*NUM_REQ-1:0] irq_lvl,
    input logic                 cpu_clk_halt,
    input logic                 osc_en,
    input logic                 stab_busy,
    input logic                 wake_pulse,
    input logic                 wake_accept,
    input logic                 sleep_rd,
    input logic                 stop_rd
);
    logic live_c;

    // Independent liveness from the raw request ports.
    always_comb begin
        live_c = 1'b0;
        for (int i = 0; i < NUM_REQ; i++)
            if (irq_req[i] && irq_lvl[2*i +: 2] != 2'b11) live_c = 1'b1;
    end

    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_halt && ctl_wr && ctl_sleep && !ctl_stop && !live_c) |=> (cpu_clk_halt && osc_en && sleep_rd));
    p_stop_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_halt && ctl_wr && ctl_stop && !live_c) |=> (!osc_en && stop_rd && !sleep_rd));
    p_stop_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_rd && !stab_busy) |-> !osc_en);
    p_block_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_halt && live_c) |=> !cpu_clk_halt);
    p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_rd && !live_c) |=> sleep_rd);
    p_sleep_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_rd && live_c) |=> (wake_pulse && !cpu_clk_halt && !stab_busy));
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
    p_settle_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stab_busy |-> (cpu_clk_halt && osc_en));
    p_readback_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (!sleep_rd && !stop_rd && !cpu_clk_halt));
    p_accept_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_accept |-> wake_pulse);
endmodule

bind stby_ctrl stby_ctrl_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_sleep    (ctl_sleep),
    .ctl_stop     (ctl_stop),
    .irq_req      (irq_req),
    .irq_lvl      (irq_lvl),
    .cpu_clk_halt (cpu_clk_halt),
    .osc_en       (osc_en),
    .stab_busy    (stab_busy),
    .wake_pulse   (wake_pulse),
    .wake_accept  (wake_accept),
    .sleep_rd     (sleep_rd),
    .stop_rd      (stop_rd)
);

// File: tb/stby_ctrl_test.sv
// Self-checking bench for stby_ctrl: vector table for the accept decision, then directed cases.
module stby_ctrl_test;
    localparam int NREQ = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ctl_wr = 1'b0, ctl_sleep = 1'b0, ctl_stop = 1'b0;
    logic [NREQ-1:0] irq_req = '0;
    logic [2*NREQ-1:0] irq_lvl = '1;
    logic [1:0]      cpu_mask_lvl = 2'b11;
    logic            cpu_ie = 1'b0;
    logic [1:0]      stab_sel = 2'b00;
    logic cpu_clk_halt, osc_en, stab_busy, wake_pulse, wake_accept, sleep_rd, stop_rd;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stby_ctrl #(.NUM_REQ(NREQ)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sleep(ctl_sleep), .ctl_stop(ctl_stop),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .cpu_mask_lvl(cpu_mask_lvl), .cpu_ie(cpu_ie),
        .stab_sel(stab_sel), .cpu_clk_halt(cpu_clk_halt), .osc_en(osc_en), .stab_busy(stab_busy),
        .wake_pulse(wake_pulse), .wake_accept(wake_accept), .sleep_rd(sleep_rd), .stop_rd(stop_rd)
    );

    // Accept table: {level, mask, ie, expected accept}.
    localparam logic [5:0] ACC_TAB [8] = '{
        {2'b00, 2'b11, 1'b1, 1'b1},
        {2'b00, 2'b00, 1'b1, 1'b0},
        {2'b01, 2'b10, 1'b1, 1'b1},
        {2'b10, 2'b10, 1'b1, 1'b0},
        {2'b01, 2'b11, 1'b0, 1'b0},
        {2'b10, 2'b11, 1'b1, 1'b1},
        {2'b00, 2'b01, 1'b0, 1'b0},
        {2'b00, 2'b01, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_bits(input logic s, input logic p);
        ctl_wr = 1'b1; ctl_sleep = s; ctl_stop = p;
        tick();
        ctl_wr = 1'b0; ctl_sleep = 1'b0; ctl_stop = 1'b0;
    endtask

    task automatic set_req(input int idx, input logic [1:0] lvl);
        irq_req[idx] = 1'b1;
        irq_lvl[2*idx +: 2] = lvl;
    endtask

    task automatic clr_req();
        irq_req = '0;
        irq_lvl = '1;
    endtask

    // Wake from stop and count busy cycles against 2^exp.
    task automatic stop_wake(input logic [1:0] sel, input int expn);
        int n;
        stab_sel = sel;
        wr_bits(1'b1, 1'b1);
        chk("R3 both bits -> stop osc_en", 32'(osc_en), 0);
        chk("R3 both bits -> stop_rd", 32'(stop_rd), 1);
        chk("R3 both bits -> sleep_rd", 32'(sleep_rd), 0);
        set_req(1, 2'b01);
        tick();
        chk("R7 osc restart", 32'(osc_en), 1);
        chk("R7 halted while busy", 32'(cpu_clk_halt), 1);
        n = 0;
        while (stab_busy && n < 20000) begin
            n++;
            if (cpu_clk_halt !== 1'b1) chk("R7 halt during settle", 32'(cpu_clk_halt), 1);
            if (wake_accept !== 1'b0) chk("R10 accept outside pulse", 32'(wake_accept), 0);
            tick();
        end
        chk("R7 busy length", 32'(n), 32'(1) << expn);
        chk("R7 pulse after settle", 32'(wake_pulse), 1);
        chk("R7 clock resumes", 32'(cpu_clk_halt), 0);
        chk("R9 stop_rd cleared", 32'(stop_rd), 0);
        clr_req();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        // R1 reset state
        chk("R1 halt", 32'(cpu_clk_halt), 0);
        chk("R1 osc_en", 32'(osc_en), 1);
        chk("R1 busy", 32'(stab_busy), 0);
        chk("R1 pulse", 32'(wake_pulse), 0);
        chk("R1 readbacks", 32'({sleep_rd, stop_rd}), 0);
        rst_n = 1'b1;
        tick();

        // Table walk: sleep, wake with one request, check the decision (R8, R6, R2).
        foreach (ACC_TAB[k]) begin
            wr_bits(1'b1, 1'b0);
            chk("R2 sleep halt", 32'(cpu_clk_halt), 1);
            chk("R2 sleep osc", 32'(osc_en), 1);
            chk("R2 sleep_rd", 32'(sleep_rd), 1);
            cpu_mask_lvl = ACC_TAB[k][3:2];
            cpu_ie = ACC_TAB[k][1];
            set_req(0, ACC_TAB[k][5:4]);
            tick();
            chk("R6 wake pulse", 32'(wake_pulse), 1);
            chk("R6 no busy", 32'(stab_busy), 0);
            chk("R8 accept", 32'(wake_accept), 32'(ACC_TAB[k][0]));
            clr_req();
            tick();
            chk("R6 pulse single", 32'(wake_pulse), 0);
            chk("R10 accept low", 32'(wake_accept), 0);
        end

        // R4: blocked entry regardless of ie, no deferred entry, later write works.
        cpu_ie = 1'b0; cpu_mask_lvl = 2'b00;
        set_req(2, 2'b10);
        wr_bits(1'b1, 1'b0);
        chk("R4 blocked sleep", 32'(cpu_clk_halt), 0);
        wr_bits(1'b0, 1'b1);
        chk("R4 blocked stop", 32'({cpu_clk_halt, sleep_rd, stop_rd}), 0);
        clr_req();
        repeat (4) tick();
        chk("R4 no deferred entry", 32'({cpu_clk_halt, sleep_rd, stop_rd}), 0);
        wr_bits(1'b1, 1'b0);
        chk("R4 entry after clear", 32'(sleep_rd), 1);
        set_req(2, 2'b00);
        tick();
        chk("R4 wake", 32'(wake_pulse), 1);
        clr_req();
        tick();

        // R5: disabled-level request does not block and does not wake.
        set_req(3, 2'b11);
        wr_bits(1'b1, 1'b0);
        chk("R5 no block", 32'(sleep_rd), 1);
        repeat (5) tick();
        chk("R5 no wake halt", 32'(cpu_clk_halt), 1);
        chk("R5 no wake pulse", 32'(wake_pulse), 0);
        // R8: best of two live levels decides (00 beats mask 01).
        cpu_ie = 1'b1; cpu_mask_lvl = 2'b01;
        set_req(0, 2'b10);
        set_req(1, 2'b00);
        tick();
        chk("R8 best level accept", 32'(wake_accept), 1);
        chk("R9 sleep_rd cleared", 32'(sleep_rd), 0);
        clr_req();
        tick();

        // R9: write with both bits 0 ignored.
        wr_bits(1'b0, 1'b0);
        repeat (2) tick();
        chk("R9 zero write ignored", 32'({cpu_clk_halt, sleep_rd, stop_rd}), 0);

        // R5 in stop: disabled request does not wake.
        wr_bits(1'b0, 1'b1);
        set_req(0, 2'b11);
        repeat (3) tick();
        chk("R5 stop no wake", 32'({osc_en, stab_busy}), 0);
        set_req(1, 2'b10);
        tick();
        chk("R5 real request wakes stop", 32'(stab_busy), 1);
        clr_req();
        repeat (20) tick();
        chk("R7 resumed after settle", 32'(cpu_clk_halt), 0);

        // R7 stop wake with each count.
        cpu_ie = 1'b0;
        stop_wake(2'b00, 4);
        stop_wake(2'b01, 8);
        stop_wake(2'b10, 12);
        stop_wake(2'b11, 14);

        // R1 mid-standby reset.
        wr_bits(1'b0, 1'b1);
        rst_n = 1'b0;
        tick();
        chk("R1 reset from stop", 32'({cpu_clk_halt, osc_en, stop_rd}), 32'b010);
        rst_n = 1'b1;
        tick();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule